// File: doc/BRIEF.md
# NAND Controller Register Front End with Keyed Lock and Interrupt Latch

This block is the register face of a NAND flash controller. A host reaches it over a plain 32-bit register bus (write strobe, read strobe, word address, write data, combinational read data). It keeps an interface configuration word and a bus timing word that are guarded by a keyed lock, a six-bit interrupt mask, a six-bit interrupt status latch that empties when it is read, and a live status word that reports ready flags and the outcome of the last ECC decode. Event pulses from the rest of the controller (flash ready, controller ready, ECC done, decode error, decode failure, write-protect fault) and a corrected-error count feed it; a level interrupt request leaves it.

The lock is a two-state machine, SHUT and OPEN. Transition UNLOCK (SHUT to OPEN) happens when the key is written to the key word; transition CONSUME (OPEN to SHUT) happens on the one accepted protected write; transition REKEY happens when any other value is written to the key word (to SHUT), and transition SOFT_RESET forces SHUT on the reset command. The command word takes 0xFF as a soft reset that brings every register back to its default; any other command value marks the start of a new flash operation and empties the live status word.

Word addresses: 0 command, 1 key, 2 configuration, 3 timing, 4 interrupt mask, 5 interrupt status, 6 live status; address 7 and the command word read as zero.

Top module: `nreg_front`

## Requirements
- R1: After reset every register reads zero, except the timing word, which reads TIME_RST (default 0x0001234); the key word reads 0 and irq is low.
- R2: A write to the key word whose low 16 bits equal 0xA25E (upper 16 bits ignored) opens the lock, and the key word then reads 1; a write of any other value to the key word shuts it and it reads 0.
- R3: While open, exactly one write to the configuration word or the timing word is accepted, and the lock shuts again in the same cycle; a further protected write needs the key again.
- R4: A write to the configuration or timing word while the lock is shut has no effect on the stored value.
- R5: The configuration word keeps bits 3:0 (bit 3 write-protect enable, bit 2 large-block device, bit 1 five-byte addressing, bit 0 16-bit bus) and reads zero above; the timing word keeps bits 26:0 and reads zero above.
- R6: Interrupt mask (bits 5:0, writable at any time) and interrupt status share one layout: bit 5 flash ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault; an event pulse sets its status bit in the next cycle.
- R7: A read of the interrupt status word returns its current contents and clears all its bits at that clock edge.
- R8: An event that arrives in the same cycle as a status read is left set after the read.
- R9: irq is high exactly while some status bit and its mask bit are both set.
- R10: The live status word reads: bit 6 decoder failure, bits 5:4 corrected count minus one, bit 3 errors detected, bit 2 ECC ready, bit 1 controller ready, bit 0 flash ready. An ECC-ready pulse loads bits 6:2 from the decode inputs (bits 5:4 zero when no error); flash-ready and controller-ready pulses set bits 0 and 1.
- R11: Writing a command other than 0xFF (low 8 bits) clears the live status word; an event pulse in that same cycle still sets its bit.
- R12: Writing 0xFF (low 8 bits) to the command word restores all defaults of R1 and shuts the lock, overriding events in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| ev_nand_rdy | input | 1 | Flash ready pulse |
| ev_ctl_rdy | input | 1 | Controller ready pulse |
| ev_dec_fail | input | 1 | Uncorrectable decode pulse |
| ev_dec_err | input | 1 | Correctable error pulse |
| ev_ecc_rdy | input | 1 | ECC result ready pulse |
| ev_wp_fault | input | 1 | Write-protect fault pulse |
| err_cnt | input | 3 | Corrected symbol count, 1 to 4, valid with ev_dec_err |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that at most one register access happens per cycle at the bus, that a strobe lasts exactly one cycle, and that err_cnt lies between 1 and 4 whenever ev_dec_err is high. The random stimulus draws one operation per cycle from a fixed seed, never asserts write and read together, and always draws the count from that range; event pulses are sprinkled independently, including in cycles that read the status word or issue commands, so the overlap rules of R8, R11 and R12 are reached alongside directed key, relock and soft-reset sequences.

// File: rtl/nreg_pkg.sv
package nreg_pkg;
    localparam int AW = 3;
    localparam int EVN = 6;
    localparam int RAW_W = 7;
    localparam int CFG_W = 4;

    localparam logic [AW-1:0] A_CMD  = 3'd0;
    localparam logic [AW-1:0] A_KEY  = 3'd1;
    localparam logic [AW-1:0] A_CFG  = 3'd2;
    localparam logic [AW-1:0] A_TIME = 3'd3;
    localparam logic [AW-1:0] A_MASK = 3'd4;
    localparam logic [AW-1:0] A_STAT = 3'd5;
    localparam logic [AW-1:0] A_RAW  = 3'd6;

    localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
    localparam logic [7:0]  SOFT_RST_CMD = 8'hFF;

    typedef enum logic {LK_SHUT, LK_OPEN} lock_e;
endpackage

// File: rtl/nreg_lock_fsm.sv
module nreg_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic key_wr,
    input  logic key_ok,
    input  logic prot_wr,
    output logic open_o
);
    import nreg_pkg::*;
    lock_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = LK_SHUT;                       // SOFT_RESET
        end else if (key_wr) begin
            st_d = key_ok ? LK_OPEN : LK_SHUT;    // UNLOCK / REKEY
        end else begin
            unique case (st_q)
                LK_SHUT: st_d = LK_SHUT;
                LK_OPEN: if (prot_wr) st_d = LK_SHUT; // CONSUME
                default: st_d = LK_SHUT;
            endcase
        end
    end

    always_comb open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/nreg_irq_bank.sv
module nreg_irq_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] evt,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_in,
    input  logic         stat_rd,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] stat_q,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask_q <= '0;
        else if (soft_rst) mask_q <= '0;
        else if (mask_wr)  mask_q <= mask_in;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stat_q[i] <= 1'b0;
            else if (soft_rst) stat_q[i] <= 1'b0;
            else if (evt[i])   stat_q[i] <= 1'b1;
            else if (stat_rd)  stat_q[i] <= 1'b0;
        end
    end

    always_comb irq = |(stat_q & mask_q);
endmodule

// File: rtl/nreg_raw_stat.sv
module nreg_raw_stat #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          op_start,
    input  logic          nand_ev,
    input  logic          ctl_ev,
    input  logic          ecc_ev,
    input  logic          fail_in,
    input  logic          err_in,
    input  logic [CW-1:0] cnt_in,
    output logic [6:0]    raw_q
);
    logic [6:0]    raw_d;
    logic [CW-1:0] cnt_m1;

    always_comb begin
        cnt_m1 = cnt_in - CW'(1);
        raw_d  = op_start ? 7'd0 : raw_q;
        if (ecc_ev) begin
            raw_d[6]   = fail_in;
            raw_d[5:4] = err_in ? cnt_m1[1:0] : 2'd0;
            raw_d[3]   = err_in;
            raw_d[2]   = 1'b1;
        end
        if (ctl_ev)  raw_d[1] = 1'b1;
        if (nand_ev) raw_d[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_q <= '0;
        else if (soft_rst) raw_q <= '0;
        else               raw_q <= raw_d;
    end
endmodule

// File: rtl/nreg_front.sv
module nreg_front #(
    parameter int          TIME_W   = 27,
    parameter logic [31:0] TIME_RST = 32'h0000_1234,
    parameter int          CNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ev_nand_rdy,
    input  logic              ev_ctl_rdy,
    input  logic              ev_dec_fail,
    input  logic              ev_dec_err,
    input  logic              ev_ecc_rdy,
    input  logic              ev_wp_fault,
    input  logic [CNT_W-1:0]  err_cnt,
    output logic              irq
);
    import nreg_pkg::*;

    logic              soft_rst, op_start, key_wr, key_ok, prot_wr, lock_open;
    logic [CFG_W-1:0]  cfg_q;
    logic [TIME_W-1:0] time_q;
    logic [EVN-1:0]    evt, mask_q, stat_q;
    logic [RAW_W-1:0]  raw_q;

    always_comb begin
        soft_rst = bus_wr && bus_addr == A_CMD && bus_wdata[7:0] == SOFT_RST_CMD;
        op_start = bus_wr && bus_addr == A_CMD && bus_wdata[7:0] != SOFT_RST_CMD;
        key_wr   = bus_wr && bus_addr == A_KEY;
        key_ok   = bus_wdata[15:0] == UNLOCK_KEY;
        prot_wr  = bus_wr && (bus_addr == A_CFG || bus_addr == A_TIME);
        evt      = {ev_nand_rdy, ev_ctl_rdy, ev_dec_fail, ev_dec_err, ev_ecc_rdy, ev_wp_fault};
    end

    nreg_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .key_wr(key_wr),
        .key_ok(key_ok), .prot_wr(prot_wr), .open_o(lock_open)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            time_q <= TIME_RST[TIME_W-1:0];
        end else if (soft_rst) begin
            cfg_q  <= '0;
            time_q <= TIME_RST[TIME_W-1:0];
        end else if (prot_wr && lock_open) begin
            if (bus_addr == A_CFG) cfg_q  <= bus_wdata[CFG_W-1:0];
            else                   time_q <= bus_wdata[TIME_W-1:0];
        end
    end

    nreg_irq_bank #(.N(EVN)) u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt(evt),
        .mask_wr(bus_wr && bus_addr == A_MASK), .mask_in(bus_wdata[EVN-1:0]),
        .stat_rd(bus_rd && bus_addr == A_STAT),
        .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
    );

    nreg_raw_stat #(.CW(CNT_W)) u_raw (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .op_start(op_start),
        .nand_ev(ev_nand_rdy), .ctl_ev(ev_ctl_rdy), .ecc_ev(ev_ecc_rdy),
        .fail_in(ev_dec_fail), .err_in(ev_dec_err), .cnt_in(err_cnt),
        .raw_q(raw_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_KEY:   bus_rdata = {31'd0, lock_open};
            A_CFG:   bus_rdata = 32'(cfg_q);
            A_TIME:  bus_rdata = 32'(time_q);
            A_MASK:  bus_rdata = 32'(mask_q);
            A_STAT:  bus_rdata = 32'(stat_q);
            A_RAW:   bus_rdata = 32'(raw_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nreg_front_chk.sv
module nreg_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [5:0]  evt,
    input logic        lock_open,
    input logic [3:0]  cfg_q,
    input logic [5:0]  mask_q,
    input logic [5:0]  stat_q,
    input logic        irq
);
    logic cmd_ff;
    assign cmd_ff = bus_wr && bus_addr == 3'd0 && bus_wdata[7:0] == 8'hFF;

    // R4
    shut_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2 && !lock_open) |=> cfg_q == $past(cfg_q));
    // R3
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_open && bus_wr && (bus_addr == 3'd2 || bus_addr == 3'd3)) |=> !lock_open);
    // R7
    clr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5 && evt == 6'd0 && !cmd_ff) |=> stat_q == 6'd0);
    // R8
    keep_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt) && !cmd_ff) |=> (stat_q & $past(evt)) == $past(evt));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 6'd0) |-> !irq);
    // R12
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ff |=> (cfg_q == 4'd0 && !lock_open && stat_q == 6'd0 && mask_q == 6'd0));
endmodule

bind nreg_front nreg_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt),
    .lock_open(lock_open), .cfg_q(cfg_q), .mask_q(mask_q),
    .stat_q(stat_q), .irq(irq)
);

// File: tb/tb_nreg_front.sv
`timescale 1ns/1ps
module tb_nreg_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ev = '0;   // {nand, ctl, fail, err, ecc, wpf}
    logic [2:0]  err_cnt = 3'd1;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench model
    logic [3:0]  m_cfg;
    logic [26:0] m_time;
    logic [5:0]  m_mask, m_stat;
    logic [6:0]  m_raw;
    logic        m_open;

    always #2 clk = ~clk;

    nreg_front dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_nand_rdy(ev[5]), .ev_ctl_rdy(ev[4]), .ev_dec_fail(ev[3]),
        .ev_dec_err(ev[2]), .ev_ecc_rdy(ev[1]), .ev_wp_fault(ev[0]),
        .err_cnt(err_cnt), .irq(irq)
    );

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd1: return {31'd0, m_open};
            3'd2: return 32'(m_cfg);
            3'd3: return 32'(m_time);
            3'd4: return 32'(m_mask);
            3'd5: return 32'(m_stat);
            3'd6: return 32'(m_raw);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic model_reset();
        m_cfg = '0; m_time = 27'h0001234; m_mask = '0; m_stat = '0;
        m_raw = '0; m_open = 1'b0;
    endtask

    task automatic model_step(input logic w, input logic r, input logic [2:0] a,
                              input logic [31:0] d, input logic [5:0] e,
                              input logic [2:0] c);
        logic [1:0] cm1;
        if (w && a == 3'd0 && d[7:0] == 8'hFF) begin
            model_reset();
            return;
        end
        if (w && a == 3'd1) m_open = (d[15:0] == 16'hA25E);
        else if (w && (a == 3'd2 || a == 3'd3)) begin
            if (m_open) begin
                if (a == 3'd2) m_cfg = d[3:0]; else m_time = d[26:0];
            end
            m_open = 1'b0;
        end
        if (w && a == 3'd4) m_mask = d[5:0];
        if (r && a == 3'd5) m_stat = '0;
        m_stat = m_stat | e;
        if (w && a == 3'd0) m_raw = '0;
        if (e[1]) begin
            cm1 = 2'(c - 3'd1);
            m_raw[6] = e[3];
            m_raw[5:4] = e[2] ? cm1 : 2'd0;
            m_raw[3] = e[2];
            m_raw[2] = 1'b1;
        end
        if (e[4]) m_raw[1] = 1'b1;
        if (e[5]) m_raw[0] = 1'b1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check before the edge, update model after.
    task automatic step(input string tag, input logic w, input logic r,
                        input logic [2:0] a, input logic [31:0] d,
                        input logic [5:0] e, input logic [2:0] c);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ev = e; err_cnt = c;
        #1;
        check("R9", 32'(irq), 32'(|(m_stat & m_mask)));
        if (r) check(tag, bus_rdata, exp_rd(a));
        @(posedge clk);
        model_step(w, r, a, d, e, c);
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        step(tag, 1'b0, 1'b1, a, 32'd0, 6'd0, 3'd1);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step("R2", 1'b1, 1'b0, a, d, 6'd0, 3'd1);
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd("R1", 3'(a));

        // R4 shut write ignored
        wr(3'd2, 32'hF);
        rd("R4", 3'd2);
        // R2 key with upper bits set opens
        wr(3'd1, 32'hDEAD_A25E);
        rd("R2", 3'd1);
        // R3 one write then relock
        wr(3'd2, 32'hFFFF_FFF6);
        rd("R5", 3'd2);
        rd("R3", 3'd1);
        wr(3'd2, 32'h1);
        rd("R3", 3'd2);
        // R2 wrong key shuts
        wr(3'd1, 32'hA25E);
        wr(3'd1, 32'hA25F);
        rd("R2", 3'd1);
        wr(3'd3, 32'h0);
        rd("R4", 3'd3);
        // timing write with key
        wr(3'd1, 32'hA25E);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R5", 3'd3);

        // R6 / R9 events, mask, irq
        wr(3'd4, 32'h3F);
        step("R6", 1'b0, 1'b0, 3'd0, 32'd0, 6'b000001, 3'd1);
        rd("R6", 3'd5);
        rd("R7", 3'd5);
        // R8 event during read
        step("R8", 1'b0, 1'b1, 3'd5, 32'd0, 6'b100000, 3'd1);
        rd("R8", 3'd5);
        // R10 decode result
        step("R10", 1'b0, 1'b0, 3'd0, 32'd0, 6'b000110, 3'd4);
        rd("R10", 3'd6);
        step("R10", 1'b0, 1'b0, 3'd0, 32'd0, 6'b011010, 3'd1);
        rd("R10", 3'd6);
        // R11 command clears live status, event same cycle survives
        step("R11", 1'b1, 1'b0, 3'd0, 32'h30, 6'b100000, 3'd1);
        rd("R11", 3'd6);
        // R12 soft reset overrides events
        step("R12", 1'b1, 1'b0, 3'd0, 32'h1234_56FF, 6'b111111, 3'd2);
        for (int a = 0; a < 8; a++) rd("R12", 3'(a));

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            logic [2:0]  a;
            logic [31:0] d;
            logic [5:0]  e;
            logic [2:0]  c;
            logic        w, r;
            op = $urandom % 16;
            a  = 3'($urandom % 8);
            d  = $urandom;
            e  = '0;
            for (int b = 0; b < 6; b++) if ($urandom % 8 == 0) e[b] = 1'b1;
            c  = 3'(1 + $urandom % 4);
            w = 1'b0; r = 1'b0;
            if (op < 3) begin w = 1'b1; a = 3'd1; if (op < 2) d[15:0] = 16'hA25E; end
            else if (op < 6) begin w = 1'b1; a = 3'(2 + op % 2); end
            else if (op < 7) begin w = 1'b1; a = 3'd4; end
            else if (op < 8) begin
                w = 1'b1; a = 3'd0;
                if ($urandom % 8 != 0) d[7:0] = 8'h10; else d[7:0] = 8'hFF;
            end
            else if (op < 15) r = 1'b1;
            step(tag_of(a), w, r, a, d, e, c);
        end

        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; ev = '0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule